// File: doc/BRIEF.md
# Boot Strap Latch and Remap Decoder

This block holds the board's boot configuration and turns the upper bits of every bus address into a memory chip select. While power-on reset is held, it samples three strap pins on each clock. One strap picks the boot device type, which is either an asynchronous ROM/flash or a synchronous ROM/flash. The other two straps give the device data width. When reset ends, the straps are frozen and later pin activity has no effect.

The 32-bit address space is cut into sixteen 256 MB banks, selected by address bits [31:28]. Banks 0x0 to 0x7 drive eight asynchronous chip selects. Banks 0xC to 0xF drive four synchronous chip selects. Banks 0x4 and 0x5 also raise a PCMCIA flag. Banks 0x8 to 0xB are unmapped and raise a decode-miss flag. The zero bank is redirected to the boot device. With an asynchronous boot it reaches asynchronous select 0, and with a synchronous boot it reaches synchronous select 3. All decode outputs are registered and appear one clock after the address.

After a synchronous boot, the block issues a one-cycle request to initialise the synchronous device's mode register. The request comes on the first clock after the internal reset is released.

Top module: `boot_remap_decoder`

## Requirements
- R1: The straps are sampled on every clock while the internal reset is active. After release, `boot_sync` and `boot_width` stay constant whatever the strap pins do.
- R2: With `strap_media`=0 (asynchronous boot), `boot_width` is 2'b00 (8-bit) for straps 00, 2'b01 (16-bit) for 01, and 2'b10 (32-bit) for both 10 and 11. `boot_sync` is 0.
- R3: With `strap_media`=1 (synchronous boot), `boot_width` is 2'b01 (16-bit) for straps 00 and 01, and 2'b10 (32-bit) for 10 and 11. `boot_sync` is 1.
- R4: After a synchronous boot, `mode_init_req` is high for exactly one cycle, on the first clock after the internal reset releases. After an asynchronous boot it never rises.
- R5: A bank b in 1..7 (addr[31:28]) asserts `async_cs[b]` only. Bank 0 asserts `async_cs[0]` only when `boot_sync`=0.
- R6: A bank 0xC..0xF asserts `sync_cs[bank-12]` only.
- R7: When `boot_sync`=1, bank 0 asserts `sync_cs[3]` only and leaves `async_cs[0]` low.
- R8: `pcmcia_hit` is high exactly when the bank is 0x4 or 0x5, alongside `async_cs[4]` or `async_cs[5]`.
- R9: Banks 0x8..0xB assert no chip select and raise `decode_miss`. Every mapped bank leaves `decode_miss` low.
- R10: Decode outputs appear on the clock after the address is presented, and at most one of the twelve chip selects is high in any cycle.
- R11: While reset is active, all chip selects, `pcmcia_hit`, `decode_miss` and `mode_init_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset. Active low, asserts asynchronously and is released synchronously inside the block |
| strap_media | input | 1 | Boot type strap: 0 selects asynchronous, 1 selects synchronous |
| strap_width | input | 2 | Boot width straps |
| addr | input | 32 | Bus address |
| sync_cs | output | 4 | One-hot synchronous bank selects |
| async_cs | output | 8 | One-hot asynchronous bank selects |
| pcmcia_hit | output | 1 | Address falls in a PCMCIA bank |
| decode_miss | output | 1 | Address falls in an unmapped bank |
| boot_sync | output | 1 | Latched boot type |
| boot_width | output | 2 | Latched boot width: 00 is 8-bit, 01 is 16-bit, 10 is 32-bit |
| mode_init_req | output | 1 | One-cycle request to initialise the synchronous device's mode register |

## Verification
The assertions check four properties on every cycle:
- the latched boot configuration holds steady after release, and the mode-register request is a lone pulse that only a synchronous boot produces;
- the chip selects are never more than one-hot;
- an unmapped bank in the previous cycle yields a miss, and a zero-bank access under a synchronous boot lands on synchronous select 3;
- the PCMCIA flag is always accompanied by one of its two asynchronous selects.

Only the bench's scenarios can cover the rest. It walks all eight strap combinations and counts the request pulses each one produces. It wiggles the pins after release and confirms the frozen values. It compares the full width table and every bank's output pattern under both boot types against independently computed values.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int ADDR_W = 32;
  localparam int BANK_W = 4;

  // Encoded boot width
  localparam logic [1:0] W8  = 2'b00;
  localparam logic [1:0] W16 = 2'b01;
  localparam logic [1:0] W32 = 2'b10;

  function automatic logic [1:0] width_of(input logic media, input logic [1:0] straps);
    logic [1:0] w;
    if (straps[1])      w = W32;
    else if (media)     w = W16;
    else if (straps[0]) w = W16;
    else                w = W8;
    return w;
  endfunction
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_q,
  input  logic       media_pin,
  input  logic [1:0] width_pins,
  output logic       boot_sync,
  output logic [1:0] boot_width,
  output logic       init_pulse
);
  logic       cap_en;
  logic       media_q;
  logic [1:0] wpin_q;
  logic       armed_q, armed_d;
  logic       pulse_q, pulse_d;

  assign cap_en = !rst_q;

  // Straps carry no reset: they track the pins while reset is held
  always_ff @(posedge clk) begin
    if (cap_en) begin
      media_q <= media_pin;
      wpin_q  <= width_pins;
    end
  end

  always_comb begin
    armed_d = armed_q;
    pulse_d = 1'b0;
    if (armed_q) begin
      armed_d = 1'b0;
      pulse_d = media_q;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      armed_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pulse_q <= pulse_d;
    end
  end

  assign boot_sync  = media_q;
  assign boot_width = width_of(media_q, wpin_q);
  assign init_pulse = pulse_q;

  // R1: configuration frozen once reset has been released
  a_r1_straps_held: assert property (@(posedge clk) disable iff (!rst_q)
    $past(rst_q) |-> ($stable(boot_sync) && $stable(boot_width)));
  // R4: request is a lone pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_q)
    init_pulse |=> !init_pulse);
  // R4: only a synchronous boot requests init
  a_r4_sync_only: assert property (@(posedge clk) disable iff (!rst_q)
    init_pulse |-> boot_sync);
endmodule

// File: rtl/bank_decode.sv
module bank_decode #(
  parameter int BANK_W    = 4,
  parameter int N_SYNC    = 4,
  parameter int N_ASYNC   = 8,
  parameter int SYNC_BASE = 12,
  parameter int PCM_LO    = 4,
  parameter int PCM_HI    = 5,
  parameter int REMAP_IDX = 3
) (
  input  logic               clk,
  input  logic               rst_q,
  input  logic [BANK_W-1:0]  bank,
  input  logic               remap_sync,
  output logic [N_SYNC-1:0]  sync_cs,
  output logic [N_ASYNC-1:0] async_cs,
  output logic               pcmcia_hit,
  output logic               decode_miss
);
  localparam logic [BANK_W-1:0] PLO = BANK_W'(PCM_LO);
  localparam logic [BANK_W-1:0] PHI = BANK_W'(PCM_HI);

  logic [N_SYNC-1:0]  sync_d;
  logic [N_ASYNC-1:0] async_d;
  logic               pcm_d, miss_d;
  logic               zero_bank;

  assign zero_bank = (bank == '0);

  for (genvar g = 0; g < N_ASYNC; g++) begin : g_async
    localparam logic [BANK_W-1:0] K = BANK_W'(g);
    if (g == 0) begin : g_boot
      assign async_d[g] = zero_bank && !remap_sync;
    end else begin : g_plain
      assign async_d[g] = (bank == K);
    end
  end

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    localparam logic [BANK_W-1:0] K = BANK_W'(SYNC_BASE + g);
    if (g == REMAP_IDX) begin : g_remap
      assign sync_d[g] = (bank == K) || (zero_bank && remap_sync);
    end else begin : g_plain
      assign sync_d[g] = (bank == K);
    end
  end

  always_comb begin
    pcm_d  = (bank >= PLO) && (bank <= PHI);
    miss_d = !((|sync_d) || (|async_d));
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sync_cs     <= '0;
      async_cs    <= '0;
      pcmcia_hit  <= 1'b0;
      decode_miss <= 1'b0;
    end else begin
      sync_cs     <= sync_d;
      async_cs    <= async_d;
      pcmcia_hit  <= pcm_d;
      decode_miss <= miss_d;
    end
  end

  // R10: never more than one chip select
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({sync_cs, async_cs}));
  // R9: unmapped bank last cycle gives a miss
  a_r9_hole_miss: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(bank) >= BANK_W'(N_ASYNC) && $past(bank) < BANK_W'(SYNC_BASE))
      |-> (decode_miss && sync_cs == '0 && async_cs == '0));
  // R7: zero bank remapped under synchronous boot
  a_r7_remap: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(rst_q) && $past(remap_sync) && $past(bank) == '0)
      |-> (sync_cs[REMAP_IDX] && !async_cs[0]));
  // R8: PCMCIA flag travels with its asynchronous select
  a_r8_pcm_cs: assert property (@(posedge clk) disable iff (!rst_q)
    pcmcia_hit |-> (async_cs[PCM_LO] || async_cs[PCM_HI]));
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import boot_pkg::*;
#(
  parameter int RST_STAGES = 2,
  parameter int N_SYNC     = 4,
  parameter int N_ASYNC    = 8
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               strap_media,
  input  logic [1:0]         strap_width,
  input  logic [ADDR_W-1:0]  addr,
  output logic [N_SYNC-1:0]  sync_cs,
  output logic [N_ASYNC-1:0] async_cs,
  output logic               pcmcia_hit,
  output logic               decode_miss,
  output logic               boot_sync,
  output logic [1:0]         boot_width,
  output logic               mode_init_req
);
  localparam int SYNC_BASE = (1 << BANK_W) - N_SYNC;

  logic              rst_q;
  logic [BANK_W-1:0] bank;

  assign bank = addr[ADDR_W-1 -: BANK_W];

  por_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .por_n(por_n), .rst_q(rst_q)
  );

  strap_latch u_strap (
    .clk(clk), .rst_q(rst_q), .media_pin(strap_media), .width_pins(strap_width),
    .boot_sync(boot_sync), .boot_width(boot_width), .init_pulse(mode_init_req)
  );

  bank_decode #(
    .BANK_W(BANK_W), .N_SYNC(N_SYNC), .N_ASYNC(N_ASYNC), .SYNC_BASE(SYNC_BASE),
    .PCM_LO(4), .PCM_HI(5), .REMAP_IDX(N_SYNC - 1)
  ) u_dec (
    .clk(clk), .rst_q(rst_q), .bank(bank), .remap_sync(boot_sync),
    .sync_cs(sync_cs), .async_cs(async_cs),
    .pcmcia_hit(pcmcia_hit), .decode_miss(decode_miss)
  );
endmodule

// File: tb/boot_remap_decoder_test.sv
module boot_remap_decoder_test;
  logic        clk = 1'b0;
  logic        por_n;
  logic        strap_media;
  logic [1:0]  strap_width;
  logic [31:0] addr;
  logic [3:0]  sync_cs;
  logic [7:0]  async_cs;
  logic        pcmcia_hit, decode_miss, boot_sync, mode_init_req;
  logic [1:0]  boot_width;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  boot_remap_decoder uut (
    .clk(clk), .por_n(por_n), .strap_media(strap_media), .strap_width(strap_width),
    .addr(addr), .sync_cs(sync_cs), .async_cs(async_cs), .pcmcia_hit(pcmcia_hit),
    .decode_miss(decode_miss), .boot_sync(boot_sync), .boot_width(boot_width),
    .mode_init_req(mode_init_req)
  );

  function automatic logic [1:0] exp_width(input logic m, input logic [1:0] w);
    if (w[1]) return 2'b10;
    if (m)    return 2'b01;
    return w[0] ? 2'b01 : 2'b00;
  endfunction

  // {sync_cs, async_cs, pcmcia, miss}
  function automatic logic [13:0] exp_dec(input logic [3:0] b, input logic s);
    logic [3:0] sc = '0;
    logic [7:0] ac = '0;
    logic pm, ms;
    if (b == 0)       begin if (s) sc[3] = 1'b1; else ac[0] = 1'b1; end
    else if (b < 8)   ac[b[2:0]] = 1'b1;
    else if (b >= 12) sc[b - 12] = 1'b1;
    pm = (b == 4) || (b == 5);
    ms = (b >= 8) && (b < 12);
    return {sc, ac, pm, ms};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic dec_check(input logic [31:0] a, input string req);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    check(req, {18'd0, sync_cs, async_cs, pcmcia_hit, decode_miss},
          {18'd0, exp_dec(a[31:28], boot_sync)});
  endtask

  task automatic boot(input logic m, input logic [1:0] w);
    int pulses;
    @(negedge clk);
    por_n = 1'b0;
    strap_media = m;
    strap_width = w;
    addr = 32'h4000_0000;
    repeat (3) @(negedge clk);
    // R11: quiet during reset
    check("R11", {19'd0, sync_cs, async_cs, pcmcia_hit, mode_init_req}, 32'd0);
    check("R11", {31'd0, decode_miss}, 32'd0);
    por_n = 1'b1;
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mode_init_req) pulses++;
      if (i == 5) begin
        strap_media = ~m;
        strap_width = ~w;
      end
    end
    check("R4", pulses, m ? 1 : 0);
    check(m ? "R3" : "R2", {29'd0, boot_sync, boot_width}, {29'd0, m, exp_width(m, w)});
    check("R1", {29'd0, boot_sync, boot_width}, {29'd0, m, exp_width(m, w)});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    por_n = 1'b0;
    strap_media = 1'b0;
    strap_width = 2'b00;
    addr = '0;

    for (int c = 0; c < 8; c++) begin
      boot(c[2], c[1:0]);
      // R5, R7: zero bank follows boot type
      dec_check(32'h0000_1234, c[2] ? "R7" : "R5");
    end

    // Synchronous boot: every bank
    boot(1'b1, 2'b11);
    for (int b = 0; b < 16; b++) begin
      dec_check({b[3:0], 28'h0ABCDEF},
                (b == 0) ? "R7" : (b == 4 || b == 5) ? "R8" :
                (b < 8) ? "R5" : (b < 12) ? "R9" : "R6");
    end
    // R10: back-to-back addresses, one clock latency
    dec_check(32'hC000_0000, "R10");
    dec_check(32'h9FFF_FFFF, "R10");
    for (int i = 0; i < 150; i++) dec_check($urandom, "R10");

    // Asynchronous boot: every bank and random traffic
    boot(1'b0, 2'b01);
    for (int b = 0; b < 16; b++) begin
      dec_check({b[3:0], 28'hFFFFFFF},
                (b == 0) ? "R5" : (b == 4 || b == 5) ? "R8" :
                (b < 8) ? "R5" : (b < 12) ? "R9" : "R6");
    end
    for (int i = 0; i < 150; i++) dec_check($urandom, "R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule